// File: doc/BRIEF.md
# Wrapping Video Fetch Address Generator

This block forms the RAM address from which the display engine fetches its video bytes, and it holds the registers that set the display mode and the screen start. The CPU writes those registers through a small port with a 4-bit address. The raster generator drives the timing inputs on every tick: the horizontal count, a flag for the last line of the frame, hsync, a flag for the last character line, the character-line value and a blanking flag.

The working byte address moves across each line in steps of one 8-byte cell. It keeps a row address that is saved or restored while hsync is active, so that each character row can be fetched again for every scan line. When a step carries out of the top of the 32 KB window, the address wraps into a base that depends on the mode. The block also decodes the mode number into its column width, text flag and bits-per-pixel, and works out how many ticks a CPU access to RAM or to I/O stalls at the current beam position.

Top module: `vid_fetch_addr`

## Requirements
- R1: A write to register 2 places data bits 7:5 into screen-start bits 8:6. A write to register 3 places data bits 5:0 into screen-start bits 14:9. All other screen-start bits read as zero, so the byte address is always a multiple of 8.
- R2: A write to register 7 takes the mode from data bits 5:3. `col40` is 1 for modes 4 to 7. `textMode` is 1 for modes 3 and 6 only.
- R3: `bppSel` is 1 (2 bpp) for modes 1 and 5, 2 (4 bpp) for mode 2, and 0 (1 bpp) for every other mode. The wrap base is 0x3000 for modes 0 to 2, 0x4000 for mode 3, 0x6000 for mode 6 and 0x5800 for modes 4, 5 and 7.
- R4: On a tick where `frameEndLine` is 1 and `hCount` equals the address-reset column (H_RST_COL, default 760), the row address and the byte address both load the screen start.
- R5: On a tick with `hsyncActive` high, the row address takes the byte address if `lastCharLine` is 1. Otherwise the byte address takes the row address. A frame load in the same tick is applied first.
- R6: `fetchAddr` equals the current byte address ORed with the 4-bit `charLine`.
- R7: The byte address gains 8 only when `hCount` is below H_ACTIVE (default 640) and either `hCount` mod 8 is 0 in 80-column modes or `hCount` mod 16 is 8 in 40-column modes. This step is applied after any hsync copy in the same tick.
- R8: If bits 14:11 of the stepped address are all zero, the byte address becomes the wrap base ORed with the low 11 bits of the stepped address.
- R9: `ioStall` equals 2 plus bit 3 of `hCount`.
- R10: In 80-column modes with `inBlank` low, `ramStall` equals 2 plus (H_ACTIVE minus `hCount`) shifted right by 3. In all other cases it equals `ioStall`.
- R11: Reset selects mode 0 and a zero screen start. Writes to register addresses other than 2, 3 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regData | input | 8 | Register write data |
| hCount | input | H_W | Horizontal beam count |
| frameEndLine | input | 1 | The current line is the frame's last line |
| hsyncActive | input | 1 | Horizontal sync is active |
| lastCharLine | input | 1 | The current scan line is the last one of its character row |
| charLine | input | 4 | Scan line within the character row |
| inBlank | input | 1 | The beam is in the blanking area |
| fetchAddr | output | 15 | Video RAM fetch address |
| col40 | output | 1 | 40-column mode is selected |
| textMode | output | 1 | Text mode is selected |
| bppSel | output | 2 | Bits per pixel: 0 = 1, 1 = 2, 2 = 4 |
| ramStall | output | STALL_W | Stall, in ticks, for a CPU RAM access |
| ioStall | output | STALL_W | Stall, in ticks, for a CPU I/O access |

## Verification
A cell step and an hsync restore can land in the same tick. This happens when hsync is held high at a column inside the active width whose phase calls for a step. The bench sets this up with the row address and the byte address holding different values. It then checks that the result is the row address plus 8, which shows the copy taking effect before the increment. A frame load together with an hsync save is judged the same way: the saved row must equal the new screen start.

// File: rtl/vid_fetch_pkg.sv
package vid_fetch_pkg;
  localparam int ADDR_W = 15;

  typedef struct packed {
    logic frameLoad;
    logic hsyncSave;
    logic hsyncRestore;
    logic step;
  } addrStrobe_t;

  typedef struct packed {
    logic              col40;
    logic              text;
    logic [1:0]        bpp;
    logic [ADDR_W-1:0] wrapBase;
  } modeInfo_t;

  function automatic modeInfo_t decodeMode(input logic [2:0] mode);
    modeInfo_t m;
    m.col40 = mode[2];
    m.text  = (mode == 3'd3) || (mode == 3'd6);
    case (mode)
      3'd1, 3'd5: m.bpp = 2'd1;
      3'd2:       m.bpp = 2'd2;
      default:    m.bpp = 2'd0;
    endcase
    case (mode)
      3'd0, 3'd1, 3'd2: m.wrapBase = 15'h3000;
      3'd3:             m.wrapBase = 15'h4000;
      3'd6:             m.wrapBase = 15'h6000;
      default:          m.wrapBase = 15'h5800;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/vid_fetch_ctrl.sv
module vid_fetch_ctrl
  import vid_fetch_pkg::*;
#(
  parameter int H_W       = 10,
  parameter int H_ACTIVE  = 640,
  parameter int H_RST_COL = 760,
  parameter int STALL_W   = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [3:0]         regAddr,
  input  logic [7:0]         regData,
  input  logic [H_W-1:0]     hCount,
  input  logic               frameEndLine,
  input  logic               hsyncActive,
  input  logic               lastCharLine,
  input  logic               inBlank,
  output addrStrobe_t        strobe,
  output logic [ADDR_W-1:0]  startAddr,
  output logic [ADDR_W-1:0]  wrapBase,
  output logic               col40,
  output logic               textMode,
  output logic [1:0]         bppSel,
  output logic [STALL_W-1:0] ramStall,
  output logic [STALL_W-1:0] ioStall
);
  localparam logic [H_W-1:0] ACT_LIMIT = H_W'(H_ACTIVE);
  localparam logic [H_W-1:0] RST_COL   = H_W'(H_RST_COL);

  logic [2:0] modeReg;
  logic [2:0] startLo;   // screen-start bits 8:6
  logic [5:0] startHi;   // screen-start bits 14:9
  modeInfo_t  modeInfo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      startLo <= '0;
      startHi <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        4'h2:    startLo <= regData[7:5];
        4'h3:    startHi <= regData[5:0];
        4'h7:    modeReg <= regData[5:3];
        default: ;
      endcase
    end
  end

  always_comb begin
    modeInfo  = decodeMode(modeReg);
    col40     = modeInfo.col40;
    textMode  = modeInfo.text;
    bppSel    = modeInfo.bpp;
    wrapBase  = modeInfo.wrapBase;
    startAddr = {startHi, startLo, 6'b0};
  end

  logic inActive;
  logic stepPhase;
  always_comb begin
    inActive  = hCount < ACT_LIMIT;
    stepPhase = col40 ? (hCount[3:0] == 4'h8) : (hCount[2:0] == 3'h0);
    strobe.frameLoad    = frameEndLine && (hCount == RST_COL);
    strobe.hsyncSave    = hsyncActive && lastCharLine;
    strobe.hsyncRestore = hsyncActive && !lastCharLine;
    strobe.step         = inActive && stepPhase;
  end

  logic [H_W:0] gap;
  always_comb begin
    gap      = {1'b0, ACT_LIMIT} - {1'b0, hCount};
    ioStall  = STALL_W'(2) + STALL_W'(hCount[3]);
    ramStall = (!col40 && !inBlank) ? STALL_W'(2) + STALL_W'(gap >> 3) : ioStall;
  end
endmodule

// File: rtl/vid_fetch_dp.sv
module vid_fetch_dp
  import vid_fetch_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  addrStrobe_t       strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] wrapBase,
  input  logic [3:0]        charLine,
  output logic [ADDR_W-1:0] byteAddr,
  output logic [ADDR_W-1:0] fetchAddr
);
  localparam int LOW_W = 11;

  logic [ADDR_W-1:0] rowAddr;
  logic [ADDR_W-1:0] rowMid, byteMid, byteCopied, stepped, rowNext, byteNext;

  always_comb begin
    rowMid     = strobe.frameLoad ? startAddr : rowAddr;
    byteMid    = strobe.frameLoad ? startAddr : byteAddr;
    rowNext    = strobe.hsyncSave ? byteMid : rowMid;
    byteCopied = strobe.hsyncRestore ? rowMid : byteMid;
    stepped    = byteCopied + ADDR_W'(8);
    if (stepped[ADDR_W-1:LOW_W] == '0)
      stepped = wrapBase | {{(ADDR_W-LOW_W){1'b0}}, stepped[LOW_W-1:0]};
    byteNext   = strobe.step ? stepped : byteCopied;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowAddr  <= '0;
      byteAddr <= '0;
    end else begin
      rowAddr  <= rowNext;
      byteAddr <= byteNext;
    end
  end

  assign fetchAddr = byteAddr | {{(ADDR_W-4){1'b0}}, charLine};
endmodule

// File: rtl/vid_fetch_addr.sv
module vid_fetch_addr
  import vid_fetch_pkg::*;
#(
  parameter int H_W       = 10,
  parameter int H_ACTIVE  = 640,
  parameter int H_RST_COL = 760,
  parameter int STALL_W   = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [3:0]         regAddr,
  input  logic [7:0]         regData,
  input  logic [H_W-1:0]     hCount,
  input  logic               frameEndLine,
  input  logic               hsyncActive,
  input  logic               lastCharLine,
  input  logic [3:0]         charLine,
  input  logic               inBlank,
  output logic [14:0]        fetchAddr,
  output logic               col40,
  output logic               textMode,
  output logic [1:0]         bppSel,
  output logic [STALL_W-1:0] ramStall,
  output logic [STALL_W-1:0] ioStall
);
  addrStrobe_t       strobe;
  logic [ADDR_W-1:0] startAddr;
  logic [ADDR_W-1:0] wrapBase;
  logic [ADDR_W-1:0] byteAddr;

  vid_fetch_ctrl #(
    .H_W(H_W), .H_ACTIVE(H_ACTIVE), .H_RST_COL(H_RST_COL), .STALL_W(STALL_W)
  ) ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regData(regData),
    .hCount(hCount), .frameEndLine(frameEndLine), .hsyncActive(hsyncActive),
    .lastCharLine(lastCharLine), .inBlank(inBlank), .strobe(strobe),
    .startAddr(startAddr), .wrapBase(wrapBase), .col40(col40), .textMode(textMode),
    .bppSel(bppSel), .ramStall(ramStall), .ioStall(ioStall)
  );

  vid_fetch_dp dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startAddr(startAddr),
    .wrapBase(wrapBase), .charLine(charLine), .byteAddr(byteAddr), .fetchAddr(fetchAddr)
  );
endmodule

// File: rtl/vid_fetch_chk.sv
module vid_fetch_chk #(
  parameter int H_W       = 10,
  parameter int H_ACTIVE  = 640,
  parameter int H_RST_COL = 760,
  parameter int STALL_W   = 7
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [3:0]         regAddr,
  input logic [7:0]         regData,
  input logic [H_W-1:0]     hCount,
  input logic               frameEndLine,
  input logic               hsyncActive,
  input logic               col40,
  input logic [STALL_W-1:0] ioStall,
  input logic [14:0]        byteAddr,
  input logic [14:0]        startAddr
);
  localparam logic [H_W-1:0] ACT_LIMIT = H_W'(H_ACTIVE);
  localparam logic [H_W-1:0] RST_COL   = H_W'(H_RST_COL);

  logic stepTick;
  assign stepTick = (hCount < ACT_LIMIT) &&
                    (col40 ? (hCount[3:0] == 4'h8) : (hCount[2:0] == 3'h0));

  AST_CELL_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    byteAddr[2:0] == 3'b000); // R1

  AST_MODE_COLUMNS: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 4'h7) |=> col40 == $past(regData[5])); // R2

  AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (frameEndLine && hCount == RST_COL && !hsyncActive && !stepTick)
      |=> byteAddr == $past(startAddr)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!stepTick && !hsyncActive && !(frameEndLine && hCount == RST_COL))
      |=> $stable(byteAddr)); // R7

  AST_WRAP_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    stepTick |=> byteAddr[14:11] != 4'h0); // R8

  AST_IO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    ioStall == STALL_W'(2) + STALL_W'(hCount[3])); // R9
endmodule

bind vid_fetch_addr vid_fetch_chk #(
  .H_W(H_W), .H_ACTIVE(H_ACTIVE), .H_RST_COL(H_RST_COL), .STALL_W(STALL_W)
) chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regData(regData),
  .hCount(hCount), .frameEndLine(frameEndLine), .hsyncActive(hsyncActive),
  .col40(col40), .ioStall(ioStall), .byteAddr(byteAddr), .startAddr(startAddr)
);

// File: tb/tb_vid_fetch_addr.sv
module tb_vid_fetch_addr;
  localparam int CLK_PERIOD = 10;
  localparam int H_W = 10;
  localparam int STALL_W = 7;
  localparam logic [H_W-1:0] IDLE_H = 10'd700;
  localparam logic [H_W-1:0] RST_H  = 10'd760;

  // {col40, text, bpp[1:0], wrapBase[14:0]} per mode 0..7
  localparam logic [18:0] MODE_VEC [8] = '{
    {1'b0, 1'b0, 2'd0, 15'h3000},
    {1'b0, 1'b0, 2'd1, 15'h3000},
    {1'b0, 1'b0, 2'd2, 15'h3000},
    {1'b0, 1'b1, 2'd0, 15'h4000},
    {1'b1, 1'b0, 2'd0, 15'h5800},
    {1'b1, 1'b0, 2'd1, 15'h5800},
    {1'b1, 1'b1, 2'd0, 15'h6000},
    {1'b1, 1'b0, 2'd0, 15'h5800}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regData = '0;
  logic [H_W-1:0] hCount = IDLE_H;
  logic frameEndLine = 1'b0;
  logic hsyncActive = 1'b0;
  logic lastCharLine = 1'b0;
  logic [3:0] charLine = '0;
  logic inBlank = 1'b1;
  logic [14:0] fetchAddr;
  logic col40, textMode;
  logic [1:0] bppSel;
  logic [STALL_W-1:0] ramStall, ioStall;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  vid_fetch_addr dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regData(regData),
    .hCount(hCount), .frameEndLine(frameEndLine), .hsyncActive(hsyncActive),
    .lastCharLine(lastCharLine), .charLine(charLine), .inBlank(inBlank),
    .fetchAddr(fetchAddr), .col40(col40), .textMode(textMode), .bppSel(bppSel),
    .ramStall(ramStall), .ioStall(ioStall)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regData = d;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic frameLoad();
    frameEndLine = 1'b1; hCount = RST_H;
    tick();
    frameEndLine = 1'b0; hCount = IDLE_H;
  endtask

  task automatic steps(input int n, input logic [H_W-1:0] col);
    hCount = col;
    for (int k = 0; k < n; k++) tick();
    hCount = IDLE_H;
  endtask

  task automatic hsyncTick(input logic last, input logic [H_W-1:0] col);
    hsyncActive = 1'b1; lastCharLine = last; hCount = col;
    tick();
    hsyncActive = 1'b0; lastCharLine = 1'b0; hCount = IDLE_H;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    tick();

    // R11 reset state
    check("R11 reset col40", col40, 0);
    check("R11 reset text", textMode, 0);
    check("R11 reset bpp", bppSel, 0);
    frameLoad();
    check("R11 reset start", fetchAddr, 15'h0000);

    // R1 screen start 0x7FC0
    wr(4'h3, 8'hFF);
    wr(4'h2, 8'hFF);
    frameLoad();
    check("R1 start high", fetchAddr, 15'h7FC0);

    // R2 R3 R8 mode table walk
    for (int i = 0; i < 8; i++) begin
      logic [18:0] v;
      v = MODE_VEC[i];
      wr(4'h7, 8'(i << 3));
      check("R2 col40", col40, v[18]);
      check("R2 text", textMode, v[17]);
      check("R3 bpp", bppSel, v[16:15]);
      frameLoad();
      steps(7, v[18] ? 10'd8 : 10'd0);
      check("R7 step to top", fetchAddr, 15'h7FF8);
      steps(1, v[18] ? 10'd8 : 10'd0);
      check("R8 R3 wrap base", fetchAddr, v[14:0]);
    end

    // R11 unused writes ignored
    wr(4'h0, 8'hFF);
    wr(4'h5, 8'h00);
    wr(4'hF, 8'h08);
    check("R11 mode kept", {col40, textMode, bppSel}, {1'b1, 1'b0, 2'd0});
    frameLoad();
    check("R11 start kept", fetchAddr, 15'h7FC0);

    // R7 40-column phases (mode 4)
    wr(4'h7, 8'h20);
    wr(4'h2, 8'h00);
    wr(4'h3, 8'h18);
    frameLoad();
    check("R1 start 0x3000", fetchAddr, 15'h3000);
    steps(1, 10'd0);
    check("R7 40col col0 no step", fetchAddr, 15'h3000);
    steps(1, 10'd16);
    check("R7 40col col16 no step", fetchAddr, 15'h3000);
    steps(1, 10'd24);
    check("R7 40col col24 step", fetchAddr, 15'h3008);
    steps(1, 10'd648);
    check("R7 40col past active", fetchAddr, 15'h3008);

    // R7 80-column phases (mode 0)
    wr(4'h7, 8'h00);
    frameLoad();
    steps(1, 10'd4);
    check("R7 80col col4 no step", fetchAddr, 15'h3000);
    steps(1, 10'd640);
    check("R7 80col col640 no step", fetchAddr, 15'h3000);
    steps(3, 10'd0);
    check("R7 80col three steps", fetchAddr, 15'h3018);

    // R5 restore, save, restore
    hsyncTick(1'b0, IDLE_H);
    check("R5 restore", fetchAddr, 15'h3000);
    steps(2, 10'd0);
    hsyncTick(1'b1, IDLE_H);
    check("R5 save keeps byte", fetchAddr, 15'h3010);
    steps(1, 10'd0);
    hsyncTick(1'b0, IDLE_H);
    check("R5 restore saved row", fetchAddr, 15'h3010);

    // R5 R7 restore and step in one tick
    steps(2, 10'd0);
    hsyncTick(1'b0, 10'd0);
    check("R5 R7 restore then step", fetchAddr, 15'h3018);

    // R4 R5 frame load with save in one tick
    wr(4'h3, 8'h20);
    hsyncActive = 1'b1; lastCharLine = 1'b1; frameEndLine = 1'b1; hCount = RST_H;
    tick();
    hsyncActive = 1'b0; lastCharLine = 1'b0; frameEndLine = 1'b0; hCount = IDLE_H;
    check("R4 load", fetchAddr, 15'h4000);
    steps(1, 10'd0);
    hsyncTick(1'b0, IDLE_H);
    check("R4 R5 saved start", fetchAddr, 15'h4000);

    // R6 OR with character line
    steps(2, 10'd0);
    charLine = 4'd5;
    #1 check("R6 fetch OR", fetchAddr, 15'h4015);
    charLine = 4'd0;

    // R8 low-address wrap (mode 4 base 0x5800)
    wr(4'h7, 8'h20);
    wr(4'h3, 8'h01);
    frameLoad();
    check("R1 start 0x0200", fetchAddr, 15'h0200);
    steps(1, 10'd8);
    check("R8 low wrap", fetchAddr, 15'h5A08);

    // R9 R10 stalls
    wr(4'h7, 8'h00);
    inBlank = 1'b0; hCount = 10'd40;
    #1 check("R10 80col active", ramStall, 77);
    check("R9 io col40", ioStall, 3);
    hCount = 10'd32;
    #1 check("R9 io col32", ioStall, 2);
    check("R10 80col col32", ramStall, 78);
    inBlank = 1'b1;
    #1 check("R10 blank uses io", ramStall, 2);
    inBlank = 1'b0;
    wr(4'h7, 8'h20);
    hCount = 10'd40;
    #1 check("R10 40col uses io", ramStall, 3);
    inBlank = 1'b1; hCount = IDLE_H;

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule